// File: doc/BRIEF.md
# Supervisory Mode Sequencer with Watchdog

This block sequences a supervisory companion chip through its operating modes: a power-up reset pulse, a configuration window, a timed reset, a request phase that waits for software to prove it is alive, the run mode, and a flash-programming mode with a much longer watchdog period. It drives the active-low reset pin for the host processor and keeps one deadline counter running. That counter is reloaded on every mode change and on every accepted watchdog refresh. Each mode gives the counter its own limit and its own fallback when the limit is reached.

All timing is counted in ticks of an external 1 ms strobe. Commands reach the block as single-cycle strobes from a serial command decoder that lies outside this block. The strobes are a watchdog refresh, an incorrect refresh, a secured mode request carrying a two-bit target, a flash-exit request and a configuration write. A debug strap is sampled on the power-on event. When the strap is set, every software deadline stops acting. The reset pulses keep their timing.

Top module: `supv_mode_seq`

## Requirements
- R1: After the asynchronous reset or a `por_i` strobe, the mode is power-up reset (code 0) and `batfail_o` is 1. The mode stays there for exactly INIT_RST_MS ticks and then moves to configuration (code 1).
- R2: In configuration mode, a refresh moves the mode to normal (code 4) and clears `batfail_o`. If CFG_WIN_MS ticks pass with no refresh, the mode returns to power-up reset.
- R3: `init_wr_en_o` equals `cfg_wr_i` while the mode is configuration and is 0 in every other mode.
- R4: In normal mode, each refresh restarts the WD_MS-tick period. The mode moves to reset (code 2) when the period runs out or when an incorrect-refresh strobe arrives.
- R5: Reset mode lasts RST_MS ticks. The one exception is entry caused by supply-low while `rst_long_i` is 1, which lasts RST_LONG_MS ticks. Reset mode is always followed by normal-request (code 3).
- R6: In normal-request mode, a refresh moves the mode to normal. An incorrect refresh, or NREQ_MS ticks with no refresh, moves the mode back to reset. A secured request has no effect in this mode.
- R7: A secured request is acted on only in normal mode. Target code 0 selects reset, 1 selects configuration and 2 selects flash (code 5). Code 3 is ignored.
- R8: Flash mode uses a watchdog period of FLASH_WD_MS ticks that each refresh restarts. An incorrect refresh, an expired period or a flash-exit strobe moves the mode to reset. A flash-exit strobe in any other mode is ignored.
- R9: In flash mode, `wd_half_irq_o` pulses for one cycle on the edge of the tick that completes half of the flash period.
- R10: A supply-low indication in normal-request, normal or flash mode moves the mode to reset.
- R11: If `dbg_strap_i` was 1 at the last `por_i`, no deadline in configuration, normal-request, normal or flash mode causes a mode change. The reset pulses still run for their set lengths.
- R12: A command strobe in the same cycle as the tick that would expire a deadline takes priority, and the expiry is ignored.
- R13: `rst_n_o` is 0 exactly when the mode is power-up reset or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; same effect as a power-on event with the debug strap clear |
| tick_i | input | 1 | One-cycle 1 ms time base strobe |
| por_i | input | 1 | Power-on event strobe |
| vdd_low_i | input | 1 | Supply-low indication |
| dbg_strap_i | input | 1 | Debug strap level, sampled on `por_i` |
| rst_long_i | input | 1 | Selects the long reset pulse for supply-low entries |
| wd_refresh_i | input | 1 | Valid watchdog refresh strobe |
| wd_bad_i | input | 1 | Incorrect watchdog refresh strobe |
| sec_req_i | input | 1 | Secured mode request strobe |
| sec_tgt_i | input | 2 | Secured request target: 0 reset, 1 configuration, 2 flash, 3 none |
| flash_exit_i | input | 1 | Flash-exit command strobe |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| mode_o | output | 3 | Current mode: 0 power-up reset, 1 configuration, 2 reset, 3 normal-request, 4 normal, 5 flash |
| rst_n_o | output | 1 | Active-low reset pin level |
| batfail_o | output | 1 | Configuration-lost flag |
| init_wr_en_o | output | 1 | Write enable for the initialization registers |
| wd_half_irq_o | output | 1 | Half-period flash watchdog interrupt pulse |

## Verification
The bench builds the block with tick limits of 2, 8, 3, 6, 7, 5 and 12, in place of the millisecond values, for power-up reset, configuration window, reset, long reset, normal-request, normal watchdog and flash watchdog. With these values every deadline, including the 32-second-class flash period and its half-period interrupt, expires within a few dozen cycles, so each deadline can be approached to one tick short and then crossed. Because all limits differ, a limit taken from the wrong mode gives a different mode at the checked tick. The debug run uses 40 idle ticks, well past every limit.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [2:0] {
        M_INIT_RST = 3'd0,
        M_INIT     = 3'd1,
        M_RESET    = 3'd2,
        M_NREQ     = 3'd3,
        M_NORMAL   = 3'd4,
        M_FLASH    = 3'd5
    } mode_e;

    localparam logic [1:0] TGT_RESET = 2'd0;
    localparam logic [1:0] TGT_INIT  = 2'd1;
    localparam logic [1:0] TGT_FLASH = 2'd2;

    typedef struct packed {
        mode_e mode;
        logic  batfail;
        logic  dbg;
        logic  long_rst;
        logic  irq;
    } seq_state_t;

endpackage

// File: rtl/supv_tick_timer.sv
module supv_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o,
    output logic             half_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             last_w;

    assign last_w   = (cnt_q == limit_i - 1'b1);
    assign expire_o = tick_i && last_w;
    assign half_o   = tick_i && (cnt_q == (limit_i >> 1) - 1'b1);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = last_w ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // counter never reaches the active limit (reload on every mode entry) - R4
    assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);

endmodule

// File: rtl/supv_mode_next.sv
module supv_mode_next
    import supv_pkg::*;
(
    input  mode_e      mode_i,
    input  logic       dbg_i,
    input  logic       expire_i,
    input  logic       refresh_i,
    input  logic       bad_i,
    input  logic       sec_req_i,
    input  logic [1:0] sec_tgt_i,
    input  logic       flash_exit_i,
    input  logic       vdd_low_i,
    output mode_e      next_o,
    output logic       vdd_cause_o,
    output logic       reload_o
);
    logic timeout_w;
    assign timeout_w = expire_i && !dbg_i;

    always_comb begin
        next_o      = mode_i;
        vdd_cause_o = 1'b0;
        reload_o    = 1'b0;
        case (mode_i)
            M_INIT_RST: begin
                if (expire_i) next_o = M_INIT;
            end
            M_INIT: begin
                if (refresh_i)      next_o = M_NORMAL;
                else if (timeout_w) next_o = M_INIT_RST;
            end
            M_RESET: begin
                if (expire_i) next_o = M_NREQ;
            end
            M_NREQ: begin
                if (vdd_low_i) begin
                    next_o      = M_RESET;
                    vdd_cause_o = 1'b1;
                end else if (refresh_i) next_o = M_NORMAL;
                else if (bad_i)         next_o = M_RESET;
                else if (timeout_w)     next_o = M_RESET;
            end
            M_NORMAL: begin
                if (vdd_low_i) begin
                    next_o      = M_RESET;
                    vdd_cause_o = 1'b1;
                end else if (sec_req_i && sec_tgt_i == TGT_RESET) next_o = M_RESET;
                else if (sec_req_i && sec_tgt_i == TGT_INIT)      next_o = M_INIT;
                else if (sec_req_i && sec_tgt_i == TGT_FLASH)     next_o = M_FLASH;
                else if (refresh_i)                               reload_o = 1'b1;
                else if (bad_i)                                   next_o = M_RESET;
                else if (timeout_w)                               next_o = M_RESET;
            end
            M_FLASH: begin
                if (vdd_low_i) begin
                    next_o      = M_RESET;
                    vdd_cause_o = 1'b1;
                end else if (flash_exit_i) next_o = M_RESET;
                else if (refresh_i)        reload_o = 1'b1;
                else if (bad_i)            next_o = M_RESET;
                else if (timeout_w)        next_o = M_RESET;
            end
            default: next_o = M_INIT_RST;
        endcase
    end

endmodule

// File: rtl/supv_mode_seq.sv
module supv_mode_seq
    import supv_pkg::*;
#(
    parameter int INIT_RST_MS = 1,
    parameter int CFG_WIN_MS  = 256,
    parameter int RST_MS      = 1,
    parameter int RST_LONG_MS = 8,
    parameter int NREQ_MS     = 256,
    parameter int WD_MS       = 128,
    parameter int FLASH_WD_MS = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       por_i,
    input  logic       vdd_low_i,
    input  logic       dbg_strap_i,
    input  logic       rst_long_i,
    input  logic       wd_refresh_i,
    input  logic       wd_bad_i,
    input  logic       sec_req_i,
    input  logic [1:0] sec_tgt_i,
    input  logic       flash_exit_i,
    input  logic       cfg_wr_i,
    output logic [2:0] mode_o,
    output logic       rst_n_o,
    output logic       batfail_o,
    output logic       init_wr_en_o,
    output logic       wd_half_irq_o
);
    localparam int MAX_A = (INIT_RST_MS > CFG_WIN_MS) ? INIT_RST_MS : CFG_WIN_MS;
    localparam int MAX_B = (RST_MS > RST_LONG_MS) ? RST_MS : RST_LONG_MS;
    localparam int MAX_C = (NREQ_MS > WD_MS) ? NREQ_MS : WD_MS;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_E = (MAX_C > FLASH_WD_MS) ? MAX_C : FLASH_WD_MS;
    localparam int MAX_L = (MAX_D > MAX_E) ? MAX_D : MAX_E;
    localparam int CNT_W = $clog2(MAX_L + 1);

    localparam logic [CNT_W-1:0] L_INIT_RST = CNT_W'(INIT_RST_MS);
    localparam logic [CNT_W-1:0] L_CFG      = CNT_W'(CFG_WIN_MS);
    localparam logic [CNT_W-1:0] L_RST      = CNT_W'(RST_MS);
    localparam logic [CNT_W-1:0] L_RST_LONG = CNT_W'(RST_LONG_MS);
    localparam logic [CNT_W-1:0] L_NREQ     = CNT_W'(NREQ_MS);
    localparam logic [CNT_W-1:0] L_WD       = CNT_W'(WD_MS);
    localparam logic [CNT_W-1:0] L_FLASH    = CNT_W'(FLASH_WD_MS);

    localparam seq_state_t ST_RESET = '{mode: M_INIT_RST, batfail: 1'b1,
                                        dbg: 1'b0, long_rst: 1'b0, irq: 1'b0};

    seq_state_t       st_d, st_q;
    mode_e            nxt_w;
    logic             vdd_cause_w, reload_w, expire_w, half_w, clear_w;
    logic [CNT_W-1:0] limit_w;

    // deadline length selected by the current mode
    always_comb begin
        case (st_q.mode)
            M_INIT_RST: limit_w = L_INIT_RST;
            M_INIT:     limit_w = L_CFG;
            M_RESET:    limit_w = st_q.long_rst ? L_RST_LONG : L_RST;
            M_NREQ:     limit_w = L_NREQ;
            M_NORMAL:   limit_w = L_WD;
            M_FLASH:    limit_w = L_FLASH;
            default:    limit_w = L_INIT_RST;
        endcase
    end

    supv_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_w),
        .tick_i   (tick_i),
        .limit_i  (limit_w),
        .expire_o (expire_w),
        .half_o   (half_w)
    );

    supv_mode_next u_next (
        .mode_i       (st_q.mode),
        .dbg_i        (st_q.dbg),
        .expire_i     (expire_w),
        .refresh_i    (wd_refresh_i),
        .bad_i        (wd_bad_i),
        .sec_req_i    (sec_req_i),
        .sec_tgt_i    (sec_tgt_i),
        .flash_exit_i (flash_exit_i),
        .vdd_low_i    (vdd_low_i),
        .next_o       (nxt_w),
        .vdd_cause_o  (vdd_cause_w),
        .reload_o     (reload_w)
    );

    assign clear_w = por_i || (nxt_w != st_q.mode) || reload_w;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (por_i) begin
            st_d.mode     = M_INIT_RST;
            st_d.batfail  = 1'b1;
            st_d.dbg      = dbg_strap_i;
            st_d.long_rst = 1'b0;
        end else begin
            st_d.mode = nxt_w;
            if (st_q.mode == M_INIT && nxt_w == M_NORMAL)
                st_d.batfail = 1'b0;
            if (nxt_w == M_RESET && st_q.mode != M_RESET)
                st_d.long_rst = vdd_cause_w && rst_long_i;
            st_d.irq = (st_q.mode == M_FLASH) && (nxt_w == M_FLASH) && half_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign mode_o        = st_q.mode;
    assign rst_n_o       = !((st_q.mode == M_INIT_RST) || (st_q.mode == M_RESET));
    assign batfail_o     = st_q.batfail;
    assign init_wr_en_o  = cfg_wr_i && (st_q.mode == M_INIT);
    assign wd_half_irq_o = st_q.irq;

    // power-up reset only leaves towards configuration - R1
    assert_initrst_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_INIT_RST && !por_i) |=> (mode_o == M_INIT_RST || mode_o == M_INIT));

    // refresh in configuration reaches normal with flag cleared - R2
    assert_cfg_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_INIT && wd_refresh_i && !por_i) |=> (mode_o == M_NORMAL && !batfail_o));

    // reset is only ever followed by normal-request - R5
    assert_reset_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RESET && !por_i) |=> (mode_o == M_RESET || mode_o == M_NREQ));

    // in debug, configuration is left only by a refresh - R11
    assert_dbg_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dbg && st_q.mode == M_INIT && !wd_refresh_i && !por_i) |=> (mode_o == M_INIT));

    // half-period interrupt is a single-cycle pulse - R9
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_half_irq_o |=> !wd_half_irq_o);

endmodule

// File: tb/supv_mode_seq_bench.sv
module supv_mode_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, por = 1'b0, vdd_low = 1'b0, dbg_strap = 1'b0, rst_long = 1'b0;
    logic       wd_refresh = 1'b0, wd_bad = 1'b0, sec_req = 1'b0, flash_exit = 1'b0, cfg_wr = 1'b0;
    logic [1:0] sec_tgt = 2'd3;
    logic [2:0] mode;
    logic       rst_pin_n, batfail, init_wr_en, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supv_mode_seq #(
        .INIT_RST_MS(2), .CFG_WIN_MS(8), .RST_MS(3), .RST_LONG_MS(6),
        .NREQ_MS(7), .WD_MS(5), .FLASH_WD_MS(12)
    ) u_supv_mode_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .por_i(por), .vdd_low_i(vdd_low),
        .dbg_strap_i(dbg_strap), .rst_long_i(rst_long), .wd_refresh_i(wd_refresh),
        .wd_bad_i(wd_bad), .sec_req_i(sec_req), .sec_tgt_i(sec_tgt),
        .flash_exit_i(flash_exit), .cfg_wr_i(cfg_wr), .mode_o(mode),
        .rst_n_o(rst_pin_n), .batfail_o(batfail), .init_wr_en_o(init_wr_en),
        .wd_half_irq_o(irq)
    );

    // cmd codes: 0 none, 1 refresh, 2 bad refresh, 3 sec->reset, 4 sec->init,
    // 5 sec->flash, 6 sec target 3, 7 flash exit, 8 supply-low long, 9 supply-low short
    // entry: {cmd[15:12], ticks[11:4], expected mode[3:0]}
    localparam int NSTEP = 39;
    localparam logic [15:0] STEPS [NSTEP] = '{
        16'h0021, 16'h0071, 16'h0010, 16'h0021, 16'h1004, 16'h0044, 16'h1044, 16'h0012,
        16'h0033, 16'h0063, 16'h0012, 16'h0033, 16'h1004, 16'h5005, 16'h00B5, 16'h10B5,
        16'h7002, 16'h0033, 16'h1004, 16'h2002, 16'h0033, 16'h1004, 16'h4001, 16'h1004,
        16'h3002, 16'h0033, 16'h1004, 16'h8002, 16'h0052, 16'h0013, 16'h1004, 16'h6004,
        16'h7004, 16'h9002, 16'h0033, 16'h2002, 16'h0033, 16'h5003, 16'h1004
    };

    function automatic string tag_of(input int c);
        case (c)
            0: return "R1/R2/R4/R5/R6";
            1: return "R2/R6";
            2: return "R4/R6";
            3, 4, 5, 6: return "R7";
            7: return "R8";
            default: return "R10/R5";
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic apply(input int c);
        wd_refresh = (c == 1);
        wd_bad     = (c == 2);
        sec_req    = (c >= 3 && c <= 6);
        sec_tgt    = (c == 3) ? 2'd0 : (c == 4) ? 2'd1 : (c == 5) ? 2'd2 : 2'd3;
        flash_exit = (c == 7);
        vdd_low    = (c == 8 || c == 9);
        rst_long   = (c == 8);
        cyc();
        wd_refresh = 1'b0; wd_bad = 1'b0; sec_req = 1'b0; sec_tgt = 2'd3;
        flash_exit = 1'b0; vdd_low = 1'b0; rst_long = 1'b0;
    endtask

    task automatic chk_mode(input string tag, input int exp);
        chk(tag, int'(mode), exp);
        chk({tag, " R13 reset pin"}, int'(rst_pin_n), (exp == 0 || exp == 2) ? 0 : 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1: reset state
        chk_mode("R1 reset mode", 0);
        chk("R1 batfail after reset", int'(batfail), 1);
        chk("R9 irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        cyc();

        for (int s = 0; s < NSTEP; s++) begin
            int c, n, m;
            c = int'(STEPS[s][15:12]);
            n = int'(STEPS[s][11:4]);
            m = int'(STEPS[s][3:0]);
            if (c != 0) apply(c);
            ticks(n);
            chk_mode($sformatf("%s step %0d", tag_of(c), s), m);
            if (s == 4) chk("R2 batfail cleared", int'(batfail), 0);
            if (s == 22) chk("R2 batfail stays clear", int'(batfail), 0);
        end

        // R12: refresh in the expiring tick wins in normal mode
        ticks(4);
        wd_refresh = 1'b1; tick = 1'b1; cyc();
        wd_refresh = 1'b0; tick = 1'b0;
        chk_mode("R12 normal refresh vs expiry", 4);
        ticks(4);
        chk_mode("R4 reloaded period", 4);
        ticks(1);
        chk_mode("R4 expired period", 2);
        ticks(3); apply(1);
        chk_mode("R6 back to normal", 4);

        // R9 and R8: half-period interrupt and flash expiry
        apply(5);
        ticks(5);
        chk("R9 irq before half", int'(irq), 0);
        ticks(1);
        chk("R9 irq at half", int'(irq), 1);
        cyc();
        chk("R9 irq single pulse", int'(irq), 0);
        ticks(5);
        chk_mode("R8 flash before expiry", 5);
        ticks(1);
        chk_mode("R8 flash expired", 2);
        ticks(3); apply(1);

        // R3: init register write enable
        cfg_wr = 1'b1; #0.1;
        chk("R3 write enable in normal", int'(init_wr_en), 0);
        cfg_wr = 1'b0;
        apply(4);
        cfg_wr = 1'b1; #0.1;
        chk("R3 write enable in config", int'(init_wr_en), 1);
        cfg_wr = 1'b0;
        // R12 in configuration: refresh on the expiring tick
        ticks(7);
        wd_refresh = 1'b1; tick = 1'b1; cyc();
        wd_refresh = 1'b0; tick = 1'b0;
        chk_mode("R12 config refresh vs expiry", 4);

        // R11: debug strap
        dbg_strap = 1'b1; por = 1'b1; cyc();
        por = 1'b0; dbg_strap = 1'b0;
        chk_mode("R1 por mode", 0);
        chk("R1 por batfail", int'(batfail), 1);
        ticks(1);
        chk_mode("R1 pulse length", 0);
        ticks(1);
        chk_mode("R1 to config", 1);
        ticks(40);
        chk_mode("R11 config holds", 1);
        apply(1); ticks(40);
        chk_mode("R11 normal holds", 4);
        apply(5); ticks(40);
        chk_mode("R11 flash holds", 5);
        apply(7); ticks(2);
        chk_mode("R11 reset pulse still timed", 2);
        ticks(1);
        chk_mode("R11 reset pulse ends", 3);
        ticks(40);
        chk_mode("R11 nreq holds", 3);
        apply(7);
        chk_mode("R8 exit ignored outside flash", 3);

        por = 1'b1; cyc(); por = 1'b0;
        ticks(2); ticks(8);
        chk_mode("R11 strap cleared by por", 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule